// File: doc/BRIEF.md
# Cache-Line Burst Address Sequencer

This block supplies the word address for each beat of a four-beat cache-line transfer. When either of two address strobes starts a transfer, it registers the external address as the line base and clears a beat counter. Each later cycle with the advance input asserted moves the counter on by one beat. The output combines the held upper address bits with low bits formed from the captured start offset and the beat count.

Two strobes can start a transfer. The processor-side strobe takes effect only while the chip-select is active. The controller-side strobe takes effect whatever the chip-select level. A static order input selects how the two low bits are formed. Linear order adds the beat count to the start offset modulo four. Interleaved order XORs the beat count into the start offset. Both orders visit all four words of the line once and then begin the same line again.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released with no start, addr_out is zero.
- R2: A rising clock edge that samples ads_proc_n low and cs_n low starts a transfer. From that edge on, addr_out equals the addr_in value sampled at that edge.
- R3: A rising edge that samples ads_proc_n low, cs_n high and ads_ctrl_n high changes nothing. addr_out keeps its value.
- R4: A rising edge that samples ads_ctrl_n low starts a transfer whatever the level of cs_n. From that edge on, addr_out equals the sampled addr_in.
- R5: With no start, an edge that samples adv_n low advances the beat count by one. An edge that samples adv_n high leaves addr_out unchanged.
- R6: With order_sel = 0 (linear), beat k has addr_out[1:0] = (s + k) mod 4, where s is the captured low two bits. Start 2 gives 2,3,0,1.
- R7: With order_sel = 1 (interleaved), beat k has addr_out[1:0] = s XOR k. Start 1 gives 1,0,3,2.
- R8: addr_out[ADDR_W-1:2] holds the captured base bits until the next start, whatever addr_in does.
- R9: If a start and adv_n low are sampled at the same edge, the start wins. addr_out shows beat 0 of the new address.
- R10: An advance after the fourth beat wraps back to beat 0 of the same line, so the fifth advance lands on the second beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ads_proc_n | input | 1 | Processor-side address strobe, active low, gated by cs_n |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low, not gated |
| cs_n | input | 1 | Primary chip-select, active low |
| adv_n | input | 1 | Beat advance enable, active low |
| order_sel | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address, sampled on a start |
| addr_out | output | ADDR_W | Current beat word address |

## Verification
Each strobe or advance takes effect at the rising edge that samples it, and addr_out shows the result within the same cycle. No output register adds a later stage. The bench therefore changes inputs on the falling edge and reads addr_out 1 ns after the next rising edge, with one expected value for each edge. order_sel acts without a clock, but it is held constant for each whole sweep. Every check is tied to exactly one sampled edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // Selects how the order logic is built.
   typedef enum logic [1:0] {
      ORD_PIN    = 2'd0,   // order chosen by the order_sel input
      ORD_LINEAR = 2'd1,   // linear order only, order_sel ignored
      ORD_XOR    = 2'd2    // interleaved order only, order_sel ignored
   } order_cfg_e;

   localparam int unsigned MAX_BEAT_BITS = 4;

endpackage

// File: rtl/burst_start_det.sv
module burst_start_det #(
   parameter bit PROC_GATED = 1'b1
) (
   input  logic ads_proc_n,
   input  logic ads_ctrl_n,
   input  logic cs_n,
   output logic start,
   output logic from_proc
);

   logic proc_ok;

   generate
      if (PROC_GATED) begin : g_gated
         assign proc_ok = ~ads_proc_n & ~cs_n;
      end else begin : g_open
         assign proc_ok = ~ads_proc_n;
      end
   endgenerate

   always_comb begin
      from_proc = proc_ok;
      start     = proc_ok | ~ads_ctrl_n;
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned BEAT_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   output logic [BEAT_BITS-1:0] cnt
);

   localparam logic [BEAT_BITS-1:0] LAST_BEAT = {BEAT_BITS{1'b1}};
   localparam logic [BEAT_BITS-1:0] ONE       = {{(BEAT_BITS-1){1'b0}}, 1'b1};

   logic [BEAT_BITS-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = cnt;
      if (load)      cnt_nxt = '0;
      else if (step) cnt_nxt = cnt + ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   // R9: a load clears the count even when a step comes at the same edge
   a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == '0));

   // R5: a step with no load moves the count forward by exactly one
   a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step && cnt != LAST_BEAT) |=> (cnt == $past(cnt) + ONE));

   // R5: with no load and no step the count holds
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(cnt));

   // R10: a step from the last beat wraps to beat zero
   a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step && cnt == LAST_BEAT) |=> (cnt == '0));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int unsigned ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // R2/R4: a load captures the address presented at that edge
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));

   // R8: the base holds between loads
   a_r8_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int unsigned BEAT_BITS = 2,
   parameter order_cfg_e  ORDER_CFG = ORD_PIN
) (
   input  logic [BEAT_BITS-1:0] start_low,
   input  logic [BEAT_BITS-1:0] beat,
   input  logic                 xor_mode,
   output logic [BEAT_BITS-1:0] low_out
);

   logic [BEAT_BITS-1:0] lin_low;
   logic [BEAT_BITS-1:0] xor_low;

   always_comb begin
      lin_low = start_low + beat;
      xor_low = start_low ^ beat;
   end

   generate
      if (ORDER_CFG == ORD_LINEAR) begin : g_lin
         logic unused_mode;
         assign unused_mode = xor_mode;
         assign low_out     = lin_low;
      end else if (ORDER_CFG == ORD_XOR) begin : g_xor
         logic unused_mode;
         assign unused_mode = xor_mode;
         assign low_out     = xor_low;
      end else begin : g_pin
         assign low_out = xor_mode ? xor_low : lin_low;
      end
   endgenerate

   // Beat zero always shows the start offset, whichever order is active.
   always_comb begin
      if (beat == '0) begin
         a_r6_beat0_offset: assert (low_out == start_low);
      end
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned BEAT_BITS  = 2,
   parameter order_cfg_e  ORDER_CFG  = ORD_PIN,
   parameter bit          PROC_GATED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ads_proc_n,
   input  logic              ads_ctrl_n,
   input  logic              cs_n,
   input  logic              adv_n,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int unsigned UPPER_W = ADDR_W - BEAT_BITS;

   generate
      if (BEAT_BITS < 1 || BEAT_BITS > MAX_BEAT_BITS) begin : g_bad_beats
         $error("burst_addr_gen: BEAT_BITS out of range");
      end
      if (ADDR_W <= BEAT_BITS) begin : g_bad_width
         $error("burst_addr_gen: ADDR_W must exceed BEAT_BITS");
      end
   endgenerate

   logic                 start;
   logic                 from_proc;
   logic [BEAT_BITS-1:0] beat;
   logic [ADDR_W-1:0]    base;
   logic [BEAT_BITS-1:0] low;
   logic                 unused_from_proc;

   assign unused_from_proc = from_proc;

   burst_start_det #(.PROC_GATED(PROC_GATED)) u_start (
      .ads_proc_n (ads_proc_n),
      .ads_ctrl_n (ads_ctrl_n),
      .cs_n       (cs_n),
      .start      (start),
      .from_proc  (from_proc)
   );

   burst_beat_ctr #(.BEAT_BITS(BEAT_BITS)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .step  (~adv_n),
      .cnt   (beat)
   );

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .d     (addr_in),
      .q     (base)
   );

   burst_order_map #(.BEAT_BITS(BEAT_BITS), .ORDER_CFG(ORDER_CFG)) u_map (
      .start_low (base[BEAT_BITS-1:0]),
      .beat      (beat),
      .xor_mode  (order_sel),
      .low_out   (low)
   );

   assign addr_out = {base[ADDR_W-1:BEAT_BITS], low};

   // R2: a gated processor strobe starts the transfer at the sampled address
   a_r2_proc_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_proc_n && !cs_n) |=> (addr_out == $past(addr_in)));

   // R4: the controller strobe starts the transfer whatever cs_n is
   a_r4_ctrl_start: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_ctrl_n |=> (addr_out == $past(addr_in)));

   // R3: with chip-select inactive and no controller strobe, the line stays put
   a_r3_cs_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && ads_ctrl_n) |=> $stable(addr_out[ADDR_W-1:BEAT_BITS]));

   // R8: the upper bits hold while no start is sampled
   a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ads_ctrl_n && (ads_proc_n || cs_n)) |=> $stable(addr_out[ADDR_W-1:BEAT_BITS]));

   // R5: no start and no advance leaves the output unchanged
   a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ads_ctrl_n && (ads_proc_n || cs_n) && adv_n && $stable(order_sel))
      |=> $stable(addr_out));

   initial begin
      if (UPPER_W == 0) $display("burst_addr_gen: no upper address bits");
   end

endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;

   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ads_proc_n = 1'b1;
   logic          ads_ctrl_n = 1'b1;
   logic          cs_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          order_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BEAT_BITS(2)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ads_proc_n (ads_proc_n),
      .ads_ctrl_n (ads_ctrl_n),
      .cs_n       (cs_n),
      .adv_n      (adv_n),
      .order_sel  (order_sel),
      .addr_in    (addr_in),
      .addr_out   (addr_out)
   );

   task automatic check(input string req, input logic [AW-1:0] exp);
      checks++;
      if (addr_out !== exp) begin
         errors++;
         $display("FAIL %s addr_out=%h expected=%h", req, addr_out, exp);
      end
   endtask

   // Drive at the falling edge, then sample 1 ns after the next rising edge.
   task automatic cyc(input logic p_n, input logic c_n, input logic cs,
                      input logic a_n, input logic [AW-1:0] a);
      @(negedge clk);
      ads_proc_n = p_n; ads_ctrl_n = c_n; cs_n = cs; adv_n = a_n; addr_in = a;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] b,
                                                 input int k, input bit xm);
      logic [1:0] s;
      logic [1:0] kk;
      s  = b[1:0];
      kk = 2'(k % 4);
      return {b[AW-1:2], xm ? (s ^ kk) : 2'(s + kk)};
   endfunction

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [AW-1:0] base;
      logic [AW-1:0] hold;
      // R1: reset state, with strobes active during reset
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
      check("R1", '0);
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'h3C);
      check("R1", '0);
      @(negedge clk); rst_n = 1'b1;
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'h77);
      check("R1", '0);

      for (int m = 0; m < 2; m++) begin
         @(negedge clk); order_sel = m[0];
         for (int s = 0; s < 4; s++) begin
            for (int u = 0; u < 3; u++) begin
               for (int src = 0; src < 2; src++) begin
                  base = {(u == 0) ? 6'h00 : (u == 1) ? 6'h15 : 6'h3F, 2'(s)};
                  if (src == 0) begin
                     cyc(1'b0, 1'b1, 1'b0, 1'b1, base);
                     check("R2", base);
                  end else begin
                     cyc(1'b1, 1'b0, 1'b1, 1'b1, base);
                     check("R4", base);
                  end
                  for (int k = 1; k <= 5; k++) begin
                     // Garbage on addr_in must not reach the upper bits (R8).
                     cyc(1'b1, 1'b1, 1'b0, 1'b0, ~base ^ 8'(k * 37));
                     check(m ? "R7" : "R6", expect_addr(base, k, m[0]));
                     if (k == 4) check("R10", base);
                     if (k == 2) begin
                        cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
                        check("R5", expect_addr(base, k, m[0]));
                     end
                  end
                  check("R8", expect_addr(base, 5, m[0]));
               end
            end
         end
      end

      // R3: gated processor strobe with chip-select high does nothing
      @(negedge clk); order_sel = 1'b0;
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h42);
      check("R4", 8'h42);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      hold = 8'h43;
      check("R5", hold);
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'hC1);
      check("R3", hold);
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h9E);
      check("R3", hold);

      // R9: start and advance at the same edge, both strobe kinds
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'hB6);
      check("R9", 8'hB6);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R6", 8'hB7);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h2D);
      check("R9", 8'h2D);
      @(negedge clk); order_sel = 1'b1;
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
      check("R7", 8'h2C);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule